// File: doc/BRIEF.md
# Qualified Reset and Start Sequencer

This block owns the chip-level reset of a switch controller. An external reset request is trusted only once it has stayed high for a minimum run of sampled clock cycles. The downstream reset line goes high on the first clock edge that sees the request, so logic behind it is held at once even while the request is still being qualified. A pulse that turns out too short releases the line again and changes nothing else.

Once a qualified request is released, the block runs a fixed initialization window of 8191 clock cycles. It then raises an initialization-acknowledge flag. The downstream reset stays high past that point and drops only when the call-setup controller issues a start strobe. A new qualified request at any time clears the acknowledge flag and starts the sequence again.

Top module: `rst_start_seq`

## Requirements
- R1: A request on `hard_rst_i` qualifies only when it is sampled high on at least MIN_HIGH (default 8) consecutive rising edges. A run of 7 samples never starts an initialization.
- R2: `sys_rst_o` is 1 after the first rising edge that samples `hard_rst_i` high (one cycle, within the two-cycle bound).
- R3: `init_ack_o` becomes 1 on the INIT_CYCLES-th (default 8191) rising edge after the edge that first samples `hard_rst_i` low following a qualified request. It is 0 after the edge before that.
- R4: After initialization, `sys_rst_o` stays 1 until `start_cmd_i` is sampled high with `init_ack_o` = 1 and `hard_rst_i` = 0. It is 0 after that edge.
- R5: An unqualified pulse drives `sys_rst_o` to 1 while it lasts and returns it to its prior level on the first low sample. `init_ack_o` and any running initialization count are unaffected.
- R6: `start_cmd_i` is ignored while `init_ack_o` is 0, and also on any edge where `hard_rst_i` is sampled high.
- R7: `init_ack_o` is 0 after the edge on which a request becomes qualified.
- R8: A request that qualifies during the initialization window discards the partial count. R3 timing is measured from the new release.
- R9: From power-up, `sys_rst_o` = 1 and `init_ack_o` = 0. The block waits for a qualified request and ignores start strobes until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising-edge active |
| hard_rst_i | input | 1 | External reset request, synchronous to clk, active high |
| start_cmd_i | input | 1 | Start strobe from the call-setup controller |
| sys_rst_o | output | 1 | Registered reset to downstream logic, active high |
| init_ack_o | output | 1 | Registered flag, 1 once initialization has completed |

## Verification
A wrong phase shows up at `sys_rst_o` on the very next edge: a missed start, a release that comes too early, or a short pulse that is not followed. A run-length counter that is off by one either lets a 7-sample pulse start an initialization or refuses an 8-sample one. That error appears only as `init_ack_o` rising, or failing to rise, 8191 cycles later. A drifting initialization timer moves the `init_ack_o` edge by the error, so the bench compares every cycle and pins the exact edge on both sides.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [2:0] {
    PH_COLD  = 3'd0,
    PH_ARMED = 3'd1,
    PH_INIT  = 3'd2,
    PH_WAIT  = 3'd3,
    PH_RUN   = 3'd4
  } phase_e;
endpackage

// File: rtl/rss_qualifier.sv
module rss_qualifier #(
  parameter int MIN_HIGH = 8,
  localparam int HW = $clog2(MIN_HIGH + 1)
) (
  input  logic clk,
  input  logic req_i,
  output logic qualify_o
);
  logic [HW-1:0] run_q = '0;
  logic          live_q = 1'b0;

  assign qualify_o = req_i && (run_q == HW'(MIN_HIGH - 1));

  always_ff @(posedge clk) begin
    live_q <= 1'b1;
    if (!req_i)
      run_q <= '0;
    else if (run_q != HW'(MIN_HIGH))
      run_q <= run_q + 1'b1;
  end

  // R1
  qual_once_chk: assert property (@(posedge clk) disable iff (!live_q)
    qualify_o |=> !qualify_o);

  // R1
  qual_needs_high_chk: assert property (@(posedge clk) disable iff (!live_q)
    (!req_i) |=> !qualify_o || (MIN_HIGH == 1));
endmodule

// File: rtl/rss_init_timer.sv
module rss_init_timer #(
  parameter int INIT_CYCLES = 8191,
  localparam int CW = $clog2(INIT_CYCLES)
) (
  input  logic clk,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q = '0;
  logic          live_q = 1'b0;

  assign done_o = run_i && (cnt_q == CW'(INIT_CYCLES - 1));

  always_ff @(posedge clk) begin
    live_q <= 1'b1;
    if (clear_i)
      cnt_q <= '0;
    else if (run_i)
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!live_q)
    clear_i |=> (cnt_q == '0) && !done_o);

  // R3
  done_rewind_chk: assert property (@(posedge clk) disable iff (!live_q)
    done_o |=> (cnt_q == '0));
endmodule

// File: rtl/rss_seq_fsm.sv
module rss_seq_fsm
  import rss_pkg::*;
(
  input  logic clk,
  input  logic req_i,
  input  logic start_i,
  input  logic qualify_i,
  input  logic done_i,
  output logic tmr_clear_o,
  output logic tmr_run_o,
  output logic rst_o,
  output logic ack_o
);
  phase_e ph_q = PH_COLD;
  phase_e ph_d;
  logic   rst_q = 1'b1;
  logic   ack_q = 1'b0;
  logic   rst_d, ack_d;
  logic   live_q = 1'b0;

  always_comb begin
    ph_d  = ph_q;
    rst_d = rst_q;
    ack_d = ack_q;
    if (qualify_i) begin
      ph_d  = PH_ARMED;
      ack_d = 1'b0;
      rst_d = 1'b1;
    end else begin
      unique case (ph_q)
        PH_COLD:  rst_d = 1'b1;
        PH_ARMED: begin
          rst_d = 1'b1;
          if (!req_i) ph_d = PH_INIT;
        end
        PH_INIT: begin
          rst_d = 1'b1;
          if (done_i) begin
            ph_d  = PH_WAIT;
            ack_d = 1'b1;
          end
        end
        PH_WAIT: begin
          rst_d = 1'b1;
          if (start_i && !req_i) begin
            ph_d  = PH_RUN;
            rst_d = 1'b0;
          end
        end
        PH_RUN:   rst_d = req_i;
        default: begin
          ph_d  = PH_COLD;
          rst_d = 1'b1;
          ack_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    live_q <= 1'b1;
    ph_q   <= ph_d;
    rst_q  <= rst_d;
    ack_q  <= ack_d;
  end

  assign tmr_clear_o = (ph_q == PH_ARMED);
  assign tmr_run_o   = (ph_q == PH_INIT);
  assign rst_o       = rst_q;
  assign ack_o       = ack_q;

  // R2
  req_holds_rst_chk: assert property (@(posedge clk) disable iff (!live_q)
    req_i |=> rst_o);

  // R7
  qual_clears_ack_chk: assert property (@(posedge clk) disable iff (!live_q)
    qualify_i |=> !ack_o);

  // R6
  early_start_chk: assert property (@(posedge clk) disable iff (!live_q)
    (start_i && !ack_o) |=> rst_o);

  // R3
  ack_from_timer_chk: assert property (@(posedge clk) disable iff (!live_q)
    $rose(ack_o) |-> $past(done_i));

  // R4
  release_cause_chk: assert property (@(posedge clk) disable iff (!live_q)
    $fell(rst_o) |-> ($past(start_i) && $past(ack_o)) || $past(ph_q == PH_RUN));
endmodule

// File: rtl/rst_start_seq.sv
module rst_start_seq #(
  parameter int MIN_HIGH    = 8,
  parameter int INIT_CYCLES = 8191
) (
  input  logic clk,
  input  logic hard_rst_i,
  input  logic start_cmd_i,
  output logic sys_rst_o,
  output logic init_ack_o
);
  logic qualify, done, tmr_clear, tmr_run;

  rss_qualifier #(.MIN_HIGH(MIN_HIGH)) u_qual (
    .clk       (clk),
    .req_i     (hard_rst_i),
    .qualify_o (qualify)
  );

  rss_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_tmr (
    .clk     (clk),
    .clear_i (tmr_clear),
    .run_i   (tmr_run),
    .done_o  (done)
  );

  rss_seq_fsm u_fsm (
    .clk         (clk),
    .req_i       (hard_rst_i),
    .start_i     (start_cmd_i),
    .qualify_i   (qualify),
    .done_i      (done),
    .tmr_clear_o (tmr_clear),
    .tmr_run_o   (tmr_run),
    .rst_o       (sys_rst_o),
    .ack_o       (init_ack_o)
  );
endmodule

// File: tb/sim_rst_start_seq.sv
module sim_rst_start_seq;
  localparam int MIN  = 8;
  localparam int INIT = 8191;

  logic clk = 1'b0;
  logic req = 1'b0;
  logic st  = 1'b0;
  logic rst_w, ack_w;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;

  // reference model state (from requirements)
  int   m_hi = 0;
  int   m_ph = 0;
  int   m_cnt = 0;
  logic m_rst = 1'b1;
  logic m_ack = 1'b0;

  always #5 clk = ~clk;

  rst_start_seq #(.MIN_HIGH(MIN), .INIT_CYCLES(INIT)) u0 (
    .clk(clk), .hard_rst_i(req), .start_cmd_i(st),
    .sys_rst_o(rst_w), .init_ack_o(ack_w)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  function automatic void model_step(input logic r, input logic s);
    bit q;
    q = r && (m_hi == MIN - 1);
    if (!r) m_hi = 0;
    else if (m_hi != MIN) m_hi++;
    if (q) begin
      m_ph = 1; m_ack = 1'b0; m_rst = 1'b1;
    end else begin
      case (m_ph)
        0: m_rst = 1'b1;
        1: begin m_rst = 1'b1; if (!r) begin m_ph = 2; m_cnt = 0; end end
        2: begin
          m_rst = 1'b1; m_cnt++;
          if (m_cnt == INIT) begin m_ph = 3; m_ack = 1'b1; end
        end
        3: if (s && !r) begin m_ph = 4; m_rst = 1'b0; end
        default: m_rst = r;
      endcase
    end
  endfunction

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic tick(input logic r, input logic s);
    req = r; st = s;
    @(posedge clk);
    model_step(r, s);
    @(negedge clk);
    chk("R5 model sys_rst_o", rst_w, m_rst);
    chk("R3 model init_ack_o", ack_w, m_ack);
  endtask

  task automatic hold(input int n, input logic r);
    for (int i = 0; i < n; i++) tick(r, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // R9 power-up state
    chk("R9 reset sys_rst_o", rst_w, 1'b1);
    chk("R9 reset init_ack_o", ack_w, 1'b0);
    tick(1'b0, 1'b1);
    chk("R9 start before any reset ignored", rst_w, 1'b1);

    // R1 seven-sample pulse does not qualify
    hold(7, 1'b1);
    hold(INIT + 5, 1'b0);
    chk("R1 short pulse no init ack", ack_w, 1'b0);
    chk("R1 short pulse rst stays", rst_w, 1'b1);

    // R1/R2 eight-sample pulse qualifies
    tick(1'b1, 1'b0);
    chk("R2 rst after first high sample", rst_w, 1'b1);
    hold(MIN - 1, 1'b1);
    tick(1'b0, 1'b0);                // edge E0
    hold(100, 1'b0);
    tick(1'b0, 1'b1);
    chk("R6 start during init ignored", rst_w, 1'b1);
    hold(INIT - 1 - 101, 1'b0);      // now past edge E0+INIT-1
    chk("R3 ack not yet", ack_w, 1'b0);
    tick(1'b0, 1'b0);
    chk("R3 ack at exact edge", ack_w, 1'b1);
    chk("R4 rst held after init", rst_w, 1'b1);

    // R4/R6 start handling
    hold(20, 1'b0);
    chk("R4 rst still held", rst_w, 1'b1);
    tick(1'b1, 1'b1);
    chk("R6 start with req high ignored", rst_w, 1'b1);
    tick(1'b0, 1'b0);
    chk("R6 still held after masked start", rst_w, 1'b1);
    tick(1'b0, 1'b1);
    chk("R4 start releases rst", rst_w, 1'b0);
    chk("R4 ack kept", ack_w, 1'b1);

    // R5 short pulse while running
    tick(1'b1, 1'b0);
    chk("R5 short pulse asserts rst", rst_w, 1'b1);
    hold(2, 1'b1);
    chk("R5 ack unchanged during pulse", ack_w, 1'b1);
    tick(1'b0, 1'b0);
    chk("R5 rst released after short pulse", rst_w, 1'b0);
    chk("R5 ack unchanged after pulse", ack_w, 1'b1);

    // R7 qualified reset while running
    hold(MIN, 1'b1);
    chk("R7 ack cleared on qualify", ack_w, 1'b0);
    tick(1'b0, 1'b0);
    hold(3000, 1'b0);
    // R8 requalify mid-count
    hold(10, 1'b1);
    tick(1'b0, 1'b0);                // new E0
    hold(INIT - 1, 1'b0);
    chk("R8 ack not at old due time", ack_w, 1'b0);
    tick(1'b0, 1'b0);
    chk("R8 ack after restarted count", ack_w, 1'b1);
    tick(1'b0, 1'b1);
    chk("R4 start after restart releases", rst_w, 1'b0);

    // random mix against the model
    for (int k = 0; k < 400; k++) begin
      int plen, gap;
      plen = (($urandom % 4) == 0) ? 1 + ($urandom % 12) : 1 + ($urandom % 7);
      gap  = 1 + ($urandom % 60);
      for (int i = 0; i < plen; i++) tick(1'b1, ($urandom % 8) == 0);
      for (int i = 0; i < gap; i++) tick(1'b0, ($urandom % 20) == 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule